// File: doc/BRIEF.md
# SPI FIFO Status and Edge Interrupt Unit

This block sits beside the receive and transmit FIFOs of a serial peripheral interface controller. It turns their fill levels, their overflow and underflow event pulses, and the controller's transfer-ready and transfer-done levels into a registered twelve-bit status word. A cause register records a rising edge of each status flag, and a mask register gates the causes into a single registered interrupt line.

Software tunes when the FIFOs report "ready" through two three-bit thresholds held in a configuration word. For a word size of B bytes it programs the receive threshold as B-1 and the transmit threshold as 7-B. The same configuration word carries a flush request bit. Writing it starts a fixed-length flush strobe to both FIFOs, clears the sticky error flags, and drops back to zero on its own once the flush is over.

An interrupt handler reads the cause word, clears the bits it has serviced by writing ones to them, and can look at the status word to find flags that were already high before it unmasked them. Such flags raise no new cause.

Top module: `sfx_status_irq`

## Requirements
- R1: The status word is registered one cycle after its inputs. Bit 0 is transfer done, bit 1 is transfer ready, bit 4 is receive empty (level 0), bit 5 is receive full (level equals RD_DEPTH), bit 6 is transmit empty and bit 7 is transmit full (level equals WR_DEPTH).
- R2: Status bits 8, 9, 10 and 11 are sticky copies of the receive underflow, receive overflow, transmit underflow and transmit overflow pulses. Each stays set once a pulse is seen, until a flush.
- R3: A cause bit is set at the clock edge that follows a 0-to-1 change of its status bit. A status bit that stays high sets nothing new.
- R4: Writing a 1 to a cause bit clears it. If a new rising edge arrives in the same cycle, the bit is set.
- R5: A cause bit is set only while its mask bit is 1. Clearing a mask bit leaves an existing cause bit as it is. After reset the mask is 0.
- R6: The interrupt line is a register. It goes high one cycle after any cause bit with its mask bit set is 1, and goes low one cycle after none is.
- R7: A configuration write loads the receive threshold from bits 26:24 and the transmit threshold from bits 30:28. The configuration readback shows both thresholds at the same positions.
- R8: Status bit 2 (receive ready) is 1 when the receive level is above the receive threshold. Status bit 3 (transmit ready) is 1 when the transmit level is at or below the transmit threshold.
- R9: A configuration write with bit 9 set drives the flush output high for FLUSH_CYCLES cycles, starting in the cycle after the write. Readback bit 9 is 1 for exactly those cycles and then returns to 0 by itself.
- R10: During a flush, including the write cycle that requests it, status bits 11:8 are cleared and overflow or underflow pulses are dropped.
- R11: After reset the status word, cause word, interrupt line, thresholds and flush output are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rd_level | input | LVL_W | Receive FIFO occupancy |
| wr_level | input | LVL_W | Transmit FIFO occupancy |
| rd_unf_ev | input | 1 | Receive underflow pulse |
| rd_ovf_ev | input | 1 | Receive overflow pulse |
| wr_unf_ev | input | 1 | Transmit underflow pulse |
| wr_ovf_ev | input | 1 | Transmit overflow pulse |
| xfer_done | input | 1 | Transfer done level |
| xfer_ready | input | 1 | Transfer ready level |
| cfg_we | input | 1 | Configuration word write strobe |
| cfg_wdata | input | 32 | Configuration word write data |
| mask_we | input | 1 | Mask write strobe |
| mask_wdata | input | 12 | Mask write data |
| cause_we | input | 1 | Cause write-one-to-clear strobe |
| cause_wdata | input | 12 | Cause bits to clear |
| status | output | 12 | Status word |
| cause | output | 12 | Latched interrupt causes |
| irq | output | 1 | Registered interrupt request |
| cfg_rdata | output | 32 | Configuration readback |
| flush_o | output | 1 | Flush strobe to both FIFOs |

## Verification
A change on a level or event input shows in the status word at the next clock edge and in the cause word one edge after that. The interrupt line follows the cause word by a further edge, and configuration and mask writes take effect at the edge that samples them. The bench keeps a behavioural model that advances at every rising edge with the same sampled inputs, and compares every output at the falling edge, when all of these staged results are settled. The directed checks wait out this three-stage latency before they compare against hand-computed values.

// File: rtl/sfx_pkg.sv
package sfx_pkg;
   localparam int NFLAG     = 12;
   localparam int F_XDONE   = 0;
   localparam int F_XRDY    = 1;
   localparam int F_RRDY    = 2;
   localparam int F_WRDY    = 3;
   localparam int F_REMPTY  = 4;
   localparam int F_RFULL   = 5;
   localparam int F_WEMPTY  = 6;
   localparam int F_WFULL   = 7;
   localparam int F_STICKY0 = 8;
   localparam int NSTICKY   = 4;
   localparam int RTHR_LSB  = 24;
   localparam int WTHR_LSB  = 28;
   localparam int FLUSH_POS = 9;
   typedef logic [NFLAG-1:0] flag_vec_t;
endpackage

// File: rtl/sfx_cfg_regs.sv
module sfx_cfg_regs
   import sfx_pkg::*;
#(
   parameter int THR_W        = 3,
   parameter int FLUSH_CYCLES = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             cfg_we,
   input  logic [31:0]      cfg_wdata,
   input  logic             mask_we,
   input  flag_vec_t        mask_wdata,
   output logic [THR_W-1:0] rd_thr_o,
   output logic [THR_W-1:0] wr_thr_o,
   output flag_vec_t        mask_o,
   output logic             flush_req_o,
   output logic             flush_busy_o,
   output logic [31:0]      cfg_rdata_o
);
   localparam int CNT_W = $clog2(FLUSH_CYCLES + 1);

   logic [THR_W-1:0] rd_thr_q, wr_thr_q;
   flag_vec_t        mask_q;
   logic [CNT_W-1:0] flush_cnt_q;

   assign flush_req_o  = cfg_we && cfg_wdata[FLUSH_POS];
   assign flush_busy_o = (flush_cnt_q != '0);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rd_thr_q <= '0;
         wr_thr_q <= '0;
      end else if (cfg_we) begin
         rd_thr_q <= cfg_wdata[RTHR_LSB +: THR_W];
         wr_thr_q <= cfg_wdata[WTHR_LSB +: THR_W];
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       mask_q <= '0;
      else if (mask_we) mask_q <= mask_wdata;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)            flush_cnt_q <= '0;
      else if (flush_req_o)  flush_cnt_q <= CNT_W'(FLUSH_CYCLES);
      else if (flush_busy_o) flush_cnt_q <= flush_cnt_q - 1'b1;
   end

   always_comb begin
      cfg_rdata_o = '0;
      cfg_rdata_o[RTHR_LSB +: THR_W] = rd_thr_q;
      cfg_rdata_o[WTHR_LSB +: THR_W] = wr_thr_q;
      cfg_rdata_o[FLUSH_POS]         = flush_busy_o;
   end

   assign rd_thr_o = rd_thr_q;
   assign wr_thr_o = wr_thr_q;
   assign mask_o   = mask_q;

   p_flush_load_r9: assert property (@(posedge clk) disable iff (!rst_n)
      flush_req_o |=> (flush_cnt_q == CNT_W'(FLUSH_CYCLES)));
   p_flush_countdown_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (flush_busy_o && !flush_req_o) |=> (flush_cnt_q == $past(flush_cnt_q) - 1'b1));
   p_thr_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
      !cfg_we |=> ($stable(rd_thr_q) && $stable(wr_thr_q)));
endmodule

// File: rtl/sfx_flag_gen.sv
module sfx_flag_gen
   import sfx_pkg::*;
#(
   parameter int RD_DEPTH = 8,
   parameter int WR_DEPTH = 8,
   parameter int THR_W    = 3,
   parameter int LVL_W    = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [LVL_W-1:0] rd_level,
   input  logic [LVL_W-1:0] wr_level,
   input  logic [3:0]       err_ev,
   input  logic             xfer_done,
   input  logic             xfer_ready,
   input  logic [THR_W-1:0] rd_thr,
   input  logic [THR_W-1:0] wr_thr,
   input  logic             flush_clr,
   output flag_vec_t        status_o
);
   localparam int CW = (LVL_W > THR_W) ? LVL_W : THR_W;

   logic [F_STICKY0-1:0] lvl_d, lvl_q;
   logic [CW-1:0]        rd_lvl_x, wr_lvl_x, rd_thr_x, wr_thr_x;
   logic [NSTICKY-1:0]   sticky_q;

   assign rd_lvl_x = CW'(rd_level);
   assign wr_lvl_x = CW'(wr_level);
   assign rd_thr_x = CW'(rd_thr);
   assign wr_thr_x = CW'(wr_thr);

   always_comb begin
      lvl_d           = '0;
      lvl_d[F_XDONE]  = xfer_done;
      lvl_d[F_XRDY]   = xfer_ready;
      lvl_d[F_RRDY]   = (rd_lvl_x > rd_thr_x);
      lvl_d[F_WRDY]   = (wr_lvl_x <= wr_thr_x);
      lvl_d[F_REMPTY] = (rd_level == '0);
      lvl_d[F_RFULL]  = (rd_level == LVL_W'(RD_DEPTH));
      lvl_d[F_WEMPTY] = (wr_level == '0);
      lvl_d[F_WFULL]  = (wr_level == LVL_W'(WR_DEPTH));
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) lvl_q <= '0;
      else        lvl_q <= lvl_d;
   end

   for (genvar g = 0; g < NSTICKY; g++) begin : g_sticky
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)         sticky_q[g] <= 1'b0;
         else if (flush_clr) sticky_q[g] <= 1'b0;
         else if (err_ev[g]) sticky_q[g] <= 1'b1;
      end

      p_sticky_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
         (sticky_q[g] && !flush_clr) |=> sticky_q[g]);
      p_sticky_set_r2: assert property (@(posedge clk) disable iff (!rst_n)
         (err_ev[g] && !flush_clr) |=> sticky_q[g]);
   end

   assign status_o = {sticky_q, lvl_q};

   p_flush_clears_r10: assert property (@(posedge clk) disable iff (!rst_n)
      flush_clr |=> (status_o[NFLAG-1:F_STICKY0] == '0));
   p_rd_empty_full_r1: assert property (@(posedge clk) disable iff (!rst_n)
      !(status_o[F_REMPTY] && status_o[F_RFULL]));
   p_wr_empty_full_r1: assert property (@(posedge clk) disable iff (!rst_n)
      !(status_o[F_WEMPTY] && status_o[F_WFULL]));
endmodule

// File: rtl/sfx_cause_irq.sv
module sfx_cause_irq
   import sfx_pkg::*;
(
   input  logic      clk,
   input  logic      rst_n,
   input  flag_vec_t status_i,
   input  flag_vec_t mask_i,
   input  logic      clr_we,
   input  flag_vec_t clr_data,
   output flag_vec_t cause_o,
   output logic      irq_o
);
   flag_vec_t prev_q, cause_q;
   logic      irq_q;

   for (genvar g = 0; g < NFLAG; g++) begin : g_cell
      logic rise, clr;
      assign rise = status_i[g] && !prev_q[g] && mask_i[g];
      assign clr  = clr_we && clr_data[g];

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            prev_q[g]  <= 1'b0;
            cause_q[g] <= 1'b0;
         end else begin
            prev_q[g]  <= status_i[g];
            if (rise)     cause_q[g] <= 1'b1;
            else if (clr) cause_q[g] <= 1'b0;
         end
      end

      p_set_on_rise_r3: assert property (@(posedge clk) disable iff (!rst_n)
         (cause_q[g] && !$past(cause_q[g])) |-> ($past(status_i[g]) && !$past(prev_q[g])));
      p_masked_no_set_r5: assert property (@(posedge clk) disable iff (!rst_n)
         (!cause_q[g] && !mask_i[g]) |=> !cause_q[g]);
      p_w1c_r4: assert property (@(posedge clk) disable iff (!rst_n)
         (clr_we && clr_data[g] && !mask_i[g]) |=> !cause_q[g]);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) irq_q <= 1'b0;
      else        irq_q <= |(cause_q & mask_i);
   end

   assign cause_o = cause_q;
   assign irq_o   = irq_q;

   p_irq_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
      ((cause_q & mask_i) == '0) |=> !irq_o);
   p_irq_raise_r6: assert property (@(posedge clk) disable iff (!rst_n)
      ((cause_q & mask_i) != '0) |=> irq_o);
endmodule

// File: rtl/sfx_status_irq.sv
module sfx_status_irq
   import sfx_pkg::*;
#(
   parameter int RD_DEPTH     = 8,
   parameter int WR_DEPTH     = 8,
   parameter int THR_W        = 3,
   parameter int FLUSH_CYCLES = 4,
   parameter int LVL_W        = $clog2(((RD_DEPTH > WR_DEPTH) ? RD_DEPTH : WR_DEPTH) + 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [LVL_W-1:0] rd_level,
   input  logic [LVL_W-1:0] wr_level,
   input  logic             rd_unf_ev,
   input  logic             rd_ovf_ev,
   input  logic             wr_unf_ev,
   input  logic             wr_ovf_ev,
   input  logic             xfer_done,
   input  logic             xfer_ready,
   input  logic             cfg_we,
   input  logic [31:0]      cfg_wdata,
   input  logic             mask_we,
   input  logic [11:0]      mask_wdata,
   input  logic             cause_we,
   input  logic [11:0]      cause_wdata,
   output logic [11:0]      status,
   output logic [11:0]      cause,
   output logic             irq,
   output logic [31:0]      cfg_rdata,
   output logic             flush_o
);
   if (THR_W < 1 || THR_W > 3) begin : g_bad_thr
      $error("THR_W must be 1..3 to fit its configuration field");
   end
   if (RD_DEPTH < 1 || WR_DEPTH < 1) begin : g_bad_depth
      $error("FIFO depths must be at least 1");
   end
   if (FLUSH_CYCLES < 1) begin : g_bad_flush
      $error("FLUSH_CYCLES must be at least 1");
   end
   if (NFLAG != 12) begin : g_bad_nflag
      $error("status width mismatch");
   end

   logic [THR_W-1:0] rd_thr, wr_thr;
   flag_vec_t        mask_q, status_w, cause_w;
   logic             flush_req, flush_busy, irq_w;

   sfx_cfg_regs #(.THR_W(THR_W), .FLUSH_CYCLES(FLUSH_CYCLES)) cfg_i (
      .clk          (clk),
      .rst_n        (rst_n),
      .cfg_we       (cfg_we),
      .cfg_wdata    (cfg_wdata),
      .mask_we      (mask_we),
      .mask_wdata   (mask_wdata),
      .rd_thr_o     (rd_thr),
      .wr_thr_o     (wr_thr),
      .mask_o       (mask_q),
      .flush_req_o  (flush_req),
      .flush_busy_o (flush_busy),
      .cfg_rdata_o  (cfg_rdata)
   );

   sfx_flag_gen #(.RD_DEPTH(RD_DEPTH), .WR_DEPTH(WR_DEPTH), .THR_W(THR_W), .LVL_W(LVL_W)) flags_i (
      .clk        (clk),
      .rst_n      (rst_n),
      .rd_level   (rd_level),
      .wr_level   (wr_level),
      .err_ev     ({wr_ovf_ev, wr_unf_ev, rd_ovf_ev, rd_unf_ev}),
      .xfer_done  (xfer_done),
      .xfer_ready (xfer_ready),
      .rd_thr     (rd_thr),
      .wr_thr     (wr_thr),
      .flush_clr  (flush_req || flush_busy),
      .status_o   (status_w)
   );

   sfx_cause_irq cause_i (
      .clk      (clk),
      .rst_n    (rst_n),
      .status_i (status_w),
      .mask_i   (mask_q),
      .clr_we   (cause_we),
      .clr_data (cause_wdata),
      .cause_o  (cause_w),
      .irq_o    (irq_w)
   );

   assign status  = status_w;
   assign cause   = cause_w;
   assign irq     = irq_w;
   assign flush_o = flush_busy;
endmodule

// File: tb/sfx_status_irq_tb_top.sv
module sfx_status_irq_tb_top;
   localparam int RD_DEPTH = 8;
   localparam int WR_DEPTH = 8;
   localparam int FLUSH_CYCLES = 4;
   localparam int LVL_W = 4;

   logic clk = 1'b0, rst_n = 1'b0;
   logic [LVL_W-1:0] rd_level = '0, wr_level = '0;
   logic rd_unf_ev = 0, rd_ovf_ev = 0, wr_unf_ev = 0, wr_ovf_ev = 0;
   logic xfer_done = 0, xfer_ready = 0;
   logic cfg_we = 0, mask_we = 0, cause_we = 0;
   logic [31:0] cfg_wdata = '0;
   logic [11:0] mask_wdata = '0, cause_wdata = '0;
   logic [11:0] status, cause;
   logic irq, flush_o;
   logic [31:0] cfg_rdata;

   int n_checks = 0, n_fail = 0;
   bit finished = 0;

   always #10 clk = ~clk;

   sfx_status_irq #(.RD_DEPTH(RD_DEPTH), .WR_DEPTH(WR_DEPTH), .THR_W(3),
                    .FLUSH_CYCLES(FLUSH_CYCLES)) dut_i (
      .clk(clk), .rst_n(rst_n), .rd_level(rd_level), .wr_level(wr_level),
      .rd_unf_ev(rd_unf_ev), .rd_ovf_ev(rd_ovf_ev), .wr_unf_ev(wr_unf_ev),
      .wr_ovf_ev(wr_ovf_ev), .xfer_done(xfer_done), .xfer_ready(xfer_ready),
      .cfg_we(cfg_we), .cfg_wdata(cfg_wdata), .mask_we(mask_we),
      .mask_wdata(mask_wdata), .cause_we(cause_we), .cause_wdata(cause_wdata),
      .status(status), .cause(cause), .irq(irq), .cfg_rdata(cfg_rdata),
      .flush_o(flush_o));

   // behavioural reference model
   bit [11:0] m_st, m_pv, m_ca, m_mk;
   bit        m_irq;
   int        m_rt, m_wt, m_fc;

   always @(posedge clk) begin
      if (!rst_n) begin
         m_st = 0; m_pv = 0; m_ca = 0; m_mk = 0; m_irq = 0;
         m_rt = 0; m_wt = 0; m_fc = 0;
      end else begin
         bit [11:0] nst, nca;
         bit        freq;
         freq = cfg_we && cfg_wdata[9];
         nst = 0;
         nst[0] = xfer_done;
         nst[1] = xfer_ready;
         nst[2] = int'(rd_level) > m_rt;
         nst[3] = int'(wr_level) <= m_wt;
         nst[4] = rd_level == 0;
         nst[5] = int'(rd_level) == RD_DEPTH;
         nst[6] = wr_level == 0;
         nst[7] = int'(wr_level) == WR_DEPTH;
         if (freq || m_fc > 0) nst[11:8] = 0;
         else nst[11:8] = m_st[11:8] | {wr_ovf_ev, wr_unf_ev, rd_ovf_ev, rd_unf_ev};
         nca = (m_ca & ~(cause_we ? cause_wdata : 12'h0)) | (m_st & ~m_pv & m_mk);
         m_irq = |(m_ca & m_mk);
         m_pv = m_st;
         m_st = nst;
         m_ca = nca;
         if (mask_we) m_mk = mask_wdata;
         if (cfg_we) begin
            m_rt = int'(cfg_wdata[26:24]);
            m_wt = int'(cfg_wdata[30:28]);
         end
         if (freq) m_fc = FLUSH_CYCLES;
         else if (m_fc > 0) m_fc = m_fc - 1;
      end
   end

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      n_checks++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=0x%0h expected=0x%0h at %0t", tag, act, exp, $time);
      end
   endtask

   always @(negedge clk) begin
      if (rst_n && !finished) begin
         chk(status[1:0] == m_st[1:0] && status[7:4] == m_st[7:4], "R1 status levels",
             int'(status), int'(m_st));
         chk(status[3:2] == m_st[3:2], "R8 ready flags", int'(status[3:2]), int'(m_st[3:2]));
         chk(status[11:8] == m_st[11:8], "R2 sticky flags", int'(status[11:8]), int'(m_st[11:8]));
         chk(cause == m_ca, "R3 cause word", int'(cause), int'(m_ca));
         chk(irq == m_irq, "R6 irq line", int'(irq), int'(m_irq));
         chk(cfg_rdata[30:24] == {m_wt[2:0], 1'b0, m_rt[2:0]}, "R7 threshold readback",
             int'(cfg_rdata), (m_wt << 28) | (m_rt << 24));
         chk(cfg_rdata[9] == (m_fc > 0) && flush_o == (m_fc > 0), "R9 flush busy",
             int'(flush_o), int'(m_fc > 0));
      end
   end

   task automatic cyc(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic wr_cfg(input int rt, input int wt, input bit fl);
      @(negedge clk);
      cfg_we = 1;
      cfg_wdata = (wt << 28) | (rt << 24) | (int'(fl) << 9);
      @(negedge clk);
      cfg_we = 0;
      cfg_wdata = 0;
   endtask

   task automatic wr_mask(input logic [11:0] m);
      @(negedge clk); mask_we = 1; mask_wdata = m;
      @(negedge clk); mask_we = 0;
   endtask

   task automatic clr_cause(input logic [11:0] m);
      @(negedge clk); cause_we = 1; cause_wdata = m;
      @(negedge clk); cause_we = 0;
   endtask

   task automatic summary();
      finished = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
   endtask

   initial begin
      #(20 * 100000);
      n_checks++; n_fail++;
      $display("FAIL watchdog expired actual=running expected=finished");
      summary();
   end

   initial begin
      cyc(3);
      // R11 reset state
      chk(status == 0 && cause == 0 && irq == 0 && cfg_rdata == 0 && flush_o == 0,
          "R11 reset state", int'(status), 0);
      rst_n = 1;
      cyc(2);
      // thresholds for 4-byte words: receive 3, transmit 3
      wr_cfg(3, 3, 0);
      chk(cfg_rdata == 32'h3300_0000, "R7 field positions", int'(cfg_rdata), 32'h3300_0000);
      wr_mask(12'hFFF);
      // sweep levels
      for (int i = 0; i <= RD_DEPTH; i++) begin
         @(negedge clk);
         rd_level = LVL_W'(i);
         wr_level = LVL_W'(WR_DEPTH - i);
         cyc(1);
      end
      rd_level = 4; wr_level = 3;
      cyc(3);
      chk(status[2] == 1 && status[3] == 1, "R8 above/at threshold", int'(status[3:2]), 3);
      rd_level = 3; wr_level = 4;
      cyc(3);
      chk(status[3:2] == 0, "R8 at/above threshold", int'(status[3:2]), 0);
      xfer_done = 1;
      cyc(2);
      chk(status[0] == 1, "R1 transfer done bit", int'(status[0]), 1);
      // clear all causes and let flags stay steady
      cyc(2);
      clr_cause(12'hFFF);
      cyc(3);
      chk(cause == 0, "R4 write-one clears", int'(cause), 0);
      chk(irq == 0, "R6 irq falls", int'(irq), 0);
      chk(status[0] == 1 && cause[0] == 0, "R3 steady high flag no new cause",
          int'(cause[0]), 0);
      // sticky errors
      @(negedge clk); rd_ovf_ev = 1;
      @(negedge clk); rd_ovf_ev = 0;
      cyc(3);
      chk(status[9] == 1, "R2 receive overflow sticky", int'(status[11:8]), 2);
      chk(cause[9] == 1 && irq == 1, "R6 irq on masked cause", int'(irq), 1);
      @(negedge clk); wr_unf_ev = 1; rd_unf_ev = 1;
      @(negedge clk); wr_unf_ev = 0; rd_unf_ev = 0;
      cyc(2);
      chk(status[11:8] == 4'b0111, "R2 sticky order", int'(status[11:8]), 7);
      // mask only bit 0; raise transfer ready
      clr_cause(12'hFFF);
      wr_mask(12'h001);
      @(negedge clk); xfer_ready = 1;
      cyc(4);
      chk(cause[1] == 0 && irq == 0, "R5 masked flag sets nothing", int'(cause), 0);
      // clear and rise in the same cycle: bit 0 must survive
      xfer_done = 0;
      cyc(3);
      @(negedge clk); xfer_done = 1;
      @(negedge clk); cause_we = 1; cause_wdata = 12'h001;
      @(negedge clk); cause_we = 0;
      chk(cause[0] == 1, "R4 rise wins over clear", int'(cause[0]), 1);
      // mask removed: cause stays, irq drops
      wr_mask(12'h000);
      cyc(2);
      chk(cause[0] == 1 && irq == 0, "R5 unmask keeps cause", int'(irq), 0);
      // flush, with an event during it
      wr_cfg(3, 3, 1);
      chk(flush_o == 1 && cfg_rdata[9] == 1, "R9 flush starts", int'(flush_o), 1);
      wr_ovf_ev = 1;
      @(negedge clk); wr_ovf_ev = 0;
      cyc(FLUSH_CYCLES - 1);
      chk(flush_o == 0 && cfg_rdata[9] == 0, "R9 flush self-clears", int'(cfg_rdata[9]), 0);
      chk(status[11:8] == 0, "R10 flush clears sticky", int'(status[11:8]), 0);
      // one-byte words: receive 0, transmit 6
      wr_mask(12'hFFF);
      wr_cfg(0, 6, 0);
      for (int i = 0; i <= 8; i++) begin
         @(negedge clk);
         rd_level = LVL_W'(i % 3);
         wr_level = LVL_W'(8 - i);
         xfer_ready = i[0];
         cyc(1);
      end
      rd_level = 1; wr_level = 6;
      cyc(3);
      chk(status[3:2] == 2'b11, "R8 one-byte thresholds", int'(status[3:2]), 3);
      cyc(4);
      summary();
   end
endmodule